// File: doc/BRIEF.md
# Serial ROM-Code CRC Validator

This block sits behind a single-wire bus receiver and checks the 64-bit identification code that a device on the bus returns. The receiver hands over one bit at a time, each qualified by a strobe, least significant bit first. The block feeds every accepted bit through an 8-bit CRC shift register and also shifts it into a capture register. Once the code is complete, the capture register presents three fields: an 8-bit family code, a 48-bit serial number and an 8-bit check byte.

The last eight bits of the code are the stored check byte. Because they pass through the CRC register like the other bits, a code that arrived intact leaves a residue of zero. After the 64th accepted bit the block raises a one-cycle done pulse. Together with it comes either a valid flag (zero residue) or a reread request (non-zero residue). The controlling logic pulses start before each read. Start clears all state and may also abort a read that is under way.

Top module: `rom_code_crc_check`

## Requirements
- R1: After reset, done_o, valid_o and reread_o are low, all three field outputs are zero, and the block is ready to accept the first bit of a code.
- R2: Accepted bits fill the code least significant bit first. Code bits 7..0 (the first eight received) appear on family_o, bits 55..8 on serial_o, and bits 63..56 on check_o.
- R3: The CRC register uses x^8+x^5+x^4+1 in right-shifting form: fb = bit ^ crc[0]; crc = crc >> 1; if fb then crc ^= 8'h8C. It starts from 00h for each code. A code whose bits 63..56 equal the CRC of bits 55..0 gives valid_o. For example, data bytes 02,1C,B8,01,00,00,00 have check byte A2h.
- R4: done_o is high for exactly one cycle, in the cycle after the clock edge that accepts the 64th strobed bit.
- R5: In the cycle where done_o is high, exactly one of valid_o and reread_o is high. valid_o is high when the 64-bit residue is 00h, otherwise reread_o is high. Both are low in every cycle where done_o is low.
- R6: A code corrupted by one flipped bit, two flipped bits, any odd number of flipped bits, or a burst confined to 8 adjacent bits yields reread_o rather than valid_o.
- R7: start_i clears the bit count, the CRC register and the captured code on the next edge, aborting any partial code. A strobe in the same cycle as start_i is ignored.
- R8: After done_o, further strobes are ignored until the next start_i. The fields hold their values and no further done_o occurs.
- R9: A bit presented while strobe_i is low has no effect on the count, the CRC or the captured code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new code; clears count, CRC and capture |
| bit_i | input | 1 | Received data bit |
| strobe_i | input | 1 | bit_i is valid this cycle |
| family_o | output | 8 | Captured family code (code bits 7..0) |
| serial_o | output | 48 | Captured serial number (code bits 55..8) |
| check_o | output | 8 | Captured check byte (code bits 63..56) |
| done_o | output | 1 | One-cycle pulse after the 64th bit |
| valid_o | output | 1 | With done_o: residue was zero |
| reread_o | output | 1 | With done_o: residue was non-zero, read again |

## Verification
Several properties are checked by assertions on every cycle. done_o never lasts two cycles, and it always comes with exactly one verdict. Neither verdict appears without done_o. The CRC register is zero after a start, and the capture register holds while no bit or start arrives. Whether the verdict is actually correct depends on the bit values. This means the CRC arithmetic, the field order, the detection of each error pattern, aborts, strobes in the same cycle as a start, and strobes after completion can only be shown by the bench scenarios. Those scenarios are compared against a behavioural model on every clock.

// File: rtl/rom_code_crc_pkg.sv
// Package: shared sizes for the serial ROM-code CRC validator.
// Assumes an 8-bit reflected CRC and a 64-bit code of family/serial/check.
package rom_code_crc_pkg;
    localparam int unsigned CODE_BITS     = 64;
    localparam int unsigned CRC_W         = 8;
    localparam int unsigned FAMILY_W      = 8;
    localparam int unsigned SERIAL_W      = 48;
    localparam logic [7:0]  CRC_POLY_REFL = 8'h8C;  // x^8+x^5+x^4+1, right-shift form
endpackage

// File: rtl/crc_serial_engine.sv
// crc_serial_engine: bit-serial CRC register, LSB-first, right-shifting.
// Assumes clear_i has priority over shift_i. zero_next_o reports whether the
// register would be all zeros after absorbing bit_i this cycle.
module crc_serial_engine #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic zero_next_o
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_nx;
    logic         fb;

    assign fb = bit_i ^ crc_q[0];

    // Per-stage next value: shifted-down stage XOR the tap if present.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W - 1) begin : g_top
            assign crc_nx[i] = POLY[i] & fb;
        end else begin : g_mid
            assign crc_nx[i] = crc_q[i+1] ^ (POLY[i] & fb);
        end
    end

    assign zero_next_o = (crc_nx == '0);

    // CRC register: cleared on reset or start, advanced on an accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            crc_q <= '0;
        end else if (shift_i) begin
            crc_q <= crc_nx;
        end
    end

    AST_CRC_ZERO_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_q == '0)); // R7
endmodule

// File: rtl/bit_sequencer.sv
// bit_sequencer: counts accepted bits of one code and locks after the last.
// Assumes start_i wins over strobe_i; strobes while locked are dropped.
module bit_sequencer #(
    parameter int unsigned NBITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic strobe_i,
    output logic accept_o,
    output logic last_o,
    output logic locked_o
);
    localparam int unsigned CNT_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBITS - 1);

    logic [CNT_W-1:0] count_q;
    logic             locked_q;

    assign accept_o = strobe_i && !start_i && !locked_q;
    assign last_o   = accept_o && (count_q == LAST_IDX);
    assign locked_o = locked_q;

    // Bit counter: wraps to zero on the last bit; start clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            count_q <= '0;
        end else if (accept_o) begin
            count_q <= last_o ? '0 : count_q + 1'b1;
        end
    end

    // Lock flag: set by the final bit, released only by start or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            locked_q <= 1'b0;
        end else if (last_o) begin
            locked_q <= 1'b1;
        end
    end

    AST_LOCK_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> $past(count_q) == LAST_IDX); // R4
endmodule

// File: rtl/code_capture.sv
// code_capture: assembles the serial code by shifting bits in at the top.
// After NBITS shifts the first bit received sits in position 0.
module code_capture #(
    parameter int unsigned NBITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [NBITS-1:0] code_o
);
    logic [NBITS-1:0] code_q;

    assign code_o = code_q;

    // Capture register: cleared on start, shifted right on an accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            code_q <= '0;
        end else if (shift_i) begin
            code_q <= {bit_i, code_q[NBITS-1:1]};
        end
    end

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !shift_i) |=> $stable(code_q)); // R8
endmodule

// File: rtl/rom_code_crc_check.sv
// rom_code_crc_check: validates a serial 64-bit ROM code by zero residue.
// Assumes bits arrive LSB first with a strobe, and start precedes each code.
// done/valid/reread are registered one cycle after the last accepted bit.
module rom_code_crc_check
    import rom_code_crc_pkg::*;
#(
    parameter int unsigned NBITS  = CODE_BITS,
    parameter int unsigned CW     = CRC_W,
    parameter int unsigned FW     = FAMILY_W,
    parameter int unsigned SW     = SERIAL_W,
    parameter logic [CW-1:0] POLY = CRC_POLY_REFL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          bit_i,
    input  logic          strobe_i,
    output logic [FW-1:0] family_o,
    output logic [SW-1:0] serial_o,
    output logic [CW-1:0] check_o,
    output logic          done_o,
    output logic          valid_o,
    output logic          reread_o
);
    localparam int unsigned SER_LO = FW;
    localparam int unsigned CHK_LO = FW + SW;

    logic             accept;
    logic             last_bit;
    logic             locked;
    logic             zero_next;
    logic [NBITS-1:0] code;
    logic             done_q;
    logic             valid_q;
    logic             reread_q;

    bit_sequencer #(.NBITS(NBITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .strobe_i (strobe_i),
        .accept_o (accept),
        .last_o   (last_bit),
        .locked_o (locked)
    );

    crc_serial_engine #(.W(CW), .POLY(POLY)) u_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .shift_i     (accept),
        .bit_i       (bit_i),
        .zero_next_o (zero_next)
    );

    code_capture #(.NBITS(NBITS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .shift_i (accept),
        .bit_i   (bit_i),
        .code_o  (code)
    );

    assign family_o = code[FW-1:0];
    assign serial_o = code[SER_LO +: SW];
    assign check_o  = code[CHK_LO +: CW];

    // Completion pulse and verdict, registered off the final accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            valid_q  <= 1'b0;
            reread_q <= 1'b0;
        end else begin
            done_q   <= last_bit;
            valid_q  <= last_bit && zero_next;
            reread_q <= last_bit && !zero_next;
        end
    end

    assign done_o   = done_q;
    assign valid_o  = valid_q;
    assign reread_o = reread_q;

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot({valid_o, reread_o})); // R5
    AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !valid_o && !reread_o); // R5
    AST_DONE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> locked); // R8
endmodule

// File: tb/rom_code_crc_check_bench.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks for each requirement.
module rom_code_crc_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic [7:0]  family_o;
    logic [47:0] serial_o;
    logic [7:0]  check_o;
    logic        done_o, valid_o, reread_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rom_code_crc_check u_rom_code_crc_check (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_i(bit_i),
        .strobe_i(strobe_i), .family_o(family_o), .serial_o(serial_o),
        .check_o(check_o), .done_o(done_o), .valid_o(valid_o), .reread_o(reread_o)
    );

    // Reference CRC: bitwise definition from the requirement text.
    function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic f = v[i] ^ c[0];
            c = c >> 1;
            if (f) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] make_code(input logic [55:0] data);
        logic [63:0] v = {8'h00, data};
        return {ref_crc(v, 56), data};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    int          m_cnt = 0;
    bit          m_locked = 0;
    logic [63:0] m_code = '0;
    bit          m_done = 0, m_valid = 0, m_reread = 0;

    always @(posedge clk) begin
        m_done = 0; m_valid = 0; m_reread = 0;
        if (!rst_n || start_i) begin
            m_cnt = 0; m_locked = 0; m_code = '0;
        end else if (strobe_i && !m_locked) begin
            m_code[m_cnt] = bit_i;
            m_cnt++;
            if (m_cnt == 64) begin
                m_locked = 1; m_done = 1; m_cnt = 0;
                m_valid  = (ref_crc(m_code, 64) == 8'h00);
                m_reread = !m_valid;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4 done", done_o, m_done);
            check("R5 valid", valid_o, m_valid);
            check("R5 reread", reread_o, m_reread);
            if (m_locked || m_cnt == 0) begin
                check("R2 family", family_o, m_code[7:0]);
                check("R2 serial", serial_o, m_code[55:8]);
                check("R2 check byte", check_o, m_code[63:56]);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            start_i = 0; strobe_i = 0; bit_i = $urandom_range(0, 1);
            @(negedge clk);
        end
    endtask

    task automatic do_start();
        start_i = 1; strobe_i = 0;
        @(negedge clk);
        start_i = 0;
    endtask

    // Sends n bits LSB first; gap idle cycles (bit toggling, no strobe) between bits.
    task automatic send_bits(input logic [63:0] v, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            start_i = 0; strobe_i = 1; bit_i = v[i];
            @(negedge clk);
            strobe_i = 0;
            if (gap > 0 && i != n - 1) idle(gap);
        end
        strobe_i = 0;
    endtask

    task automatic run_code(input string tag, input logic [63:0] v, input int gap, input bit exp_ok);
        do_start();
        send_bits(v, 64, gap);
        check({tag, " done"}, done_o, 1'b1);
        check({tag, " valid"}, valid_o, exp_ok);
        check({tag, " reread"}, reread_o, !exp_ok);
        idle(2);
    endtask

    logic [63:0] good_a;
    logic [63:0] good_b;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 done", done_o, 0);
        check("R1 valid", valid_o, 0);
        check("R1 reread", reread_o, 0);
        check("R1 fields", {check_o, serial_o, family_o}, 64'h0);

        // R3: known example check byte
        good_a = make_code(56'h00000001B81C02);
        check("R3 example check byte", good_a[63:56], 8'hA2);
        run_code("R3", good_a, 0, 1);
        // R2: field positions
        check("R2 family", family_o, 8'h02);
        check("R2 serial", serial_o, 48'h00000001B81C);
        check("R2 check", check_o, 8'hA2);

        // R9: gapped strobes with toggling bits
        good_b = make_code(56'hDEADBEEF123445);
        run_code("R9 gapped", good_b, 2, 1);

        // R6: error patterns
        run_code("R6 single", good_a ^ (64'h1 << 5), 0, 0);
        run_code("R6 double", good_a ^ (64'h1 << 3) ^ (64'h1 << 40), 0, 0);
        run_code("R6 triple", good_b ^ (64'h1 << 1) ^ (64'h1 << 20) ^ (64'h1 << 60), 0, 0);
        run_code("R6 burst8", good_b ^ (64'hFF << 30), 0, 0);
        run_code("R6 burst ends", good_a ^ (64'h81 << 50), 0, 0);
        run_code("R6 check byte", good_a ^ (64'h1 << 63), 1, 0);

        // R8: strobes after done are ignored
        run_code("R8 base", good_b, 0, 1);
        send_bits(64'hFFFF_FFFF_FFFF_FFFF, 70, 0);
        check("R8 family held", family_o, good_b[7:0]);
        check("R8 serial held", serial_o, good_b[55:8]);
        check("R8 no done", done_o, 0);

        // R7: abort mid-code, then a good code
        do_start();
        send_bits(64'h0123_4567_89AB_CDEF, 20, 0);
        do_start();
        check("R7 cleared fields", {check_o, serial_o, family_o}, 64'h0);
        send_bits(good_a, 64, 0);
        check("R7 valid after abort", valid_o, 1);
        idle(1);
        // R7: strobe coincident with start is dropped
        start_i = 1; strobe_i = 1; bit_i = 1;
        @(negedge clk);
        start_i = 0;
        send_bits(good_b, 64, 0);
        check("R7 strobe with start ignored", valid_o, 1);
        idle(3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule